// File: doc/BRIEF.md
# Command Queue Drain Engine

This block empties a ring of 16-byte commands that software builds in system memory. Software sets the ring base address, its size as a power of two and the producer index with its wrap bit. While the ring is enabled and the producer and consumer positions differ, the engine fetches the command at the consumer position over a request/response read port. It classifies the opcode and either retires the command or stops with an error.

Cache and translation invalidations are treated as no-ops, because that work sits outside this engine. A synchronisation command can raise a completion interrupt. The consumer index moves only after a command has been retired. A synchronisation completion is therefore never signalled before the commands ahead of it.

Any failure freezes the ring and flips the command-error bit of the global error flags, which makes an error pending. The ring stays frozen until software makes the acknowledge bit equal to the error bit again.

Top module: `cmdq_drain`

## Requirements
- R1: While `q_en` is low, no read request is issued and the consumer index does not move.
- R2: The ring is empty when the consumer and producer indices, both masked to the ring size, are equal and their wrap bits are equal. While the ring is enabled, not empty and no error is pending, commands are fetched one after another until the ring is empty.
- R3: Each fetch reads address `q_base + 16 * consumer_index`. `rd_req_valid` stays high with a stable address until `rd_req_ready` is seen.
- R4: A command with opcode 0x46 (opcode = bits [7:0] of the response) is a sync. If its completion field, bits [13:12], equals 2'b01, `irq_sync` pulses high for one cycle. Any other field value gives no pulse.
- R5: These opcodes are retired as no-ops: 0x01–0x06, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44 and 0x45.
- R6: Any opcode other than 0x46 and those of R5 sets `cmd_err` to 1 (illegal). The command is not consumed and fetching stops.
- R7: A response with `rd_rsp_err` high sets `cmd_err` to 2 (abort). The command is not consumed and fetching stops.
- R8: On any error, `gerr_flag` toggles and `irq_gerr` pulses high for one cycle, in the same cycle.
- R9: While `gerr_flag != gerr_ack`, no fetch starts. Fetching resumes, at the same command, once they are equal.
- R10: `q_log2sz` values above `MAX_LOG2` count as `MAX_LOG2`. After entry 2^size−1 the consumer index returns to 0 and `cons_wrap` toggles.
- R11: The consumer index advances by one only on an error-free response to a legal command. The `irq_sync` pulse appears in the cycle in which the index has already advanced past that sync.
- R12: After reset, the consumer index, `cons_wrap`, `cmd_err` and `gerr_flag` are 0, and no request or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en | input | 1 | Ring enable |
| q_base | input | ADDR_W | Ring base byte address |
| q_log2sz | input | LW | log2 of ring entry count |
| prod_ptr | input | MAX_LOG2 | Producer index |
| prod_wrap | input | 1 | Producer wrap bit |
| cons_ptr | output | MAX_LOG2 | Consumer index |
| cons_wrap | output | 1 | Consumer wrap bit |
| gerr_ack | input | 1 | Acknowledge copy of the command-error bit |
| gerr_flag | output | 1 | Command-error bit of the global error flags |
| cmd_err | output | 2 | Last error code: 0 none, 1 illegal, 2 abort |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_err | input | 1 | Read response error |
| rd_rsp_data | input | CMD_W | 16-byte command |
| irq_sync | output | 1 | Sync completion pulse |
| irq_gerr | output | 1 | Global error pulse |

## Verification
Random batches mix no-op opcodes with syncs whose completion field is set and syncs whose field is not. This separates counting pulses from retiring syncs. One illegal opcode or one read abort is placed at a random position in some batches. These batches show whether the engine stops exactly at the faulty slot, and whether acknowledging resumes at that slot rather than after it. The batches run with ring sizes of one, four and a clamped sixteen entries, and with full rings, so wrap toggling and size clamping are exercised. A directed phase holds the enable low with work queued, and the stall while an error is pending is checked separately from the stall while the ring is disabled.

// File: rtl/cmdq_drain.sv
module cmdq_drain #(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 4,
  parameter int CMD_W    = 128,
  localparam int LW      = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic [ADDR_W-1:0] q_base,
  input  logic [LW-1:0]     q_log2sz,
  input  logic [MAX_LOG2-1:0] prod_ptr,
  input  logic              prod_wrap,
  output logic [MAX_LOG2-1:0] cons_ptr,
  output logic              cons_wrap,
  input  logic              gerr_ack,
  output logic              gerr_flag,
  output logic [1:0]        cmd_err,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic              rd_rsp_err,
  input  logic [CMD_W-1:0]  rd_rsp_data,
  output logic              irq_sync,
  output logic              irq_gerr
);

  localparam logic [1:0] ERR_ILL = 2'd1;
  localparam logic [1:0] ERR_ABT = 2'd2;
  localparam logic [7:0] OP_SYNC = 8'h46;
  localparam logic [1:0] CS_IRQ  = 2'b01;
  localparam int         PAD_W   = ADDR_W - MAX_LOG2 - 4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} st_t;
  st_t state;

  logic [LW-1:0]       lg;
  logic [MAX_LOG2-1:0] mask, cons_m, prod_m;
  logic                empty, pending, start;
  logic [7:0]          opcode;
  logic                op_nop, op_legal, sync_irq;

  assign lg      = (q_log2sz > LW'(MAX_LOG2)) ? LW'(MAX_LOG2) : q_log2sz;
  assign mask    = ~({MAX_LOG2{1'b1}} << lg);
  assign cons_m  = cons_ptr & mask;
  assign prod_m  = prod_ptr & mask;
  assign empty   = (cons_m == prod_m) && (cons_wrap == prod_wrap);
  assign pending = gerr_flag ^ gerr_ack;
  assign start   = q_en && !empty && !pending;

  assign opcode  = rd_rsp_data[7:0];

  always_comb begin
    case (opcode)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
      8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A,
      8'h30, 8'h40, 8'h41, 8'h44, 8'h45: op_nop = 1'b1;
      default:                           op_nop = 1'b0;
    endcase
  end

  assign op_legal = op_nop || (opcode == OP_SYNC);
  assign sync_irq = (opcode == OP_SYNC) && (rd_rsp_data[13:12] == CS_IRQ);

  assign rd_req_valid = (state == S_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cons_ptr    <= '0;
      cons_wrap   <= 1'b0;
      gerr_flag   <= 1'b0;
      cmd_err     <= '0;
      irq_sync    <= 1'b0;
      irq_gerr    <= 1'b0;
      rd_req_addr <= '0;
    end else begin
      irq_sync <= 1'b0;
      irq_gerr <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          rd_req_addr <= q_base + {{PAD_W{1'b0}}, cons_m, 4'b0000};
          state       <= S_REQ;
        end
        S_REQ: if (rd_req_ready) state <= S_RSP;
        S_RSP: if (rd_rsp_valid) begin
          state <= S_IDLE;
          if (rd_rsp_err || !op_legal) begin
            cmd_err   <= rd_rsp_err ? ERR_ABT : ERR_ILL;
            gerr_flag <= ~gerr_flag;
            irq_gerr  <= 1'b1;
          end else begin
            if (cons_m == mask) begin
              cons_ptr  <= '0;
              cons_wrap <= ~cons_wrap;
            end else begin
              cons_ptr  <= cons_m + 1'b1;
            end
            irq_sync <= sync_irq;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdq_drain_chk.sv
module cmdq_drain_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                q_en,
  input logic [MAX_LOG2-1:0] cons_ptr,
  input logic                cons_wrap,
  input logic                gerr_ack,
  input logic                gerr_flag,
  input logic [1:0]          cmd_err,
  input logic                rd_req_valid,
  input logic                rd_req_ready,
  input logic [ADDR_W-1:0]   rd_req_addr,
  input logic                rd_rsp_valid,
  input logic                rd_rsp_err,
  input logic                irq_sync,
  input logic                irq_gerr
);

  logic [MAX_LOG2:0] cons_full;
  assign cons_full = {cons_wrap, cons_ptr};

  p_fetch_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(q_en));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_err_code_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gerr |-> cmd_err != 2'd0);

  p_err_not_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gerr |-> $stable(cons_full));

  p_gerr_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gerr |-> gerr_flag != $past(gerr_flag));

  p_no_fetch_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(gerr_flag == gerr_ack));

  p_adv_on_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cons_full != $past(cons_full) |-> $past(rd_rsp_valid && !rd_rsp_err));

  p_sync_after_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sync |-> cons_full != $past(cons_full));

  p_irq_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_sync && irq_gerr));

endmodule

bind cmdq_drain cmdq_drain_chk #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .q_en(q_en), .cons_ptr(cons_ptr), .cons_wrap(cons_wrap),
  .gerr_ack(gerr_ack), .gerr_flag(gerr_flag), .cmd_err(cmd_err),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err),
  .irq_sync(irq_sync), .irq_gerr(irq_gerr));

// File: tb/cmdq_drain_tb_top.sv
module cmdq_drain_tb_top;
  localparam int AW = 32;
  localparam int ML = 4;
  localparam int LW = $clog2(ML + 1);
  localparam int NE = 1 << ML;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic q_en = 1'b0;
  logic [AW-1:0] q_base = 32'h8000_1000;
  logic [LW-1:0] q_log2sz = '0;
  logic [ML-1:0] prod_ptr = '0;
  logic prod_wrap = 1'b0;
  logic [ML-1:0] cons_ptr;
  logic cons_wrap, gerr_flag, gerr_ack = 1'b0;
  logic [1:0] cmd_err;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic [127:0] rd_rsp_data = '0;
  logic irq_sync, irq_gerr;

  cmdq_drain #(.ADDR_W(AW), .MAX_LOG2(ML), .CMD_W(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .q_base(q_base), .q_log2sz(q_log2sz),
    .prod_ptr(prod_ptr), .prod_wrap(prod_wrap), .cons_ptr(cons_ptr), .cons_wrap(cons_wrap),
    .gerr_ack(gerr_ack), .gerr_flag(gerr_flag), .cmd_err(cmd_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .rd_rsp_data(rd_rsp_data),
    .irq_sync(irq_sync), .irq_gerr(irq_gerr));

  int n_cmp = 0, n_bad = 0;
  int cnt_sync = 0, cnt_gerr = 0, cnt_fetch = 0;
  logic [127:0] mem [NE];
  bit bad [NE];
  int lgc = 0;
  logic [ML:0] fetch_pos = '0;
  logic [ML:0] exp_pos = '0;
  bit exp_gerr = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ML:0] adv(input logic [ML:0] v, input int l);
    logic [ML-1:0] m;
    m = ML'((1 << l) - 1);
    if ((v[ML-1:0] & m) == m) return {~v[ML], {ML{1'b0}}};
    return {v[ML], (v[ML-1:0] & m) + 1'b1};
  endfunction

  function automatic logic [7:0] nop_op(input int k);
    case (k % 23)
      0: return 8'h01;  1: return 8'h02;  2: return 8'h03;  3: return 8'h04;
      4: return 8'h05;  5: return 8'h06;  6: return 8'h10;  7: return 8'h11;
      8: return 8'h12;  9: return 8'h13; 10: return 8'h18; 11: return 8'h1A;
      12: return 8'h20; 13: return 8'h21; 14: return 8'h22; 15: return 8'h23;
      16: return 8'h28; 17: return 8'h2A; 18: return 8'h30; 19: return 8'h40;
      20: return 8'h41; 21: return 8'h44; default: return 8'h45;
    endcase
  endfunction

  function automatic bit legal(input logic [7:0] op);
    if (op == 8'h46) return 1'b1;
    for (int k = 0; k < 23; k++) if (nop_op(k) == op) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] ill_op(input int k);
    case (k % 5)
      0: return 8'h00; 1: return 8'h07; 2: return 8'h7F; 3: return 8'hFF;
      default: return 8'h47;
    endcase
  endfunction

  bit have_rsp = 1'b0;
  int rsp_cnt = 0;
  int rsp_idx = 0;
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
    if (irq_sync) cnt_sync++;
    if (irq_gerr) cnt_gerr++;
    if (have_rsp) begin
      if (rsp_cnt == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_err   = bad[rsp_idx];
        rd_rsp_data  = mem[rsp_idx];
        have_rsp     = 1'b0;
        if (!bad[rsp_idx] && legal(mem[rsp_idx][7:0])) fetch_pos = adv(fetch_pos, lgc);
      end else rsp_cnt--;
      rd_req_ready = 1'b0;
    end else begin
      rd_req_ready = ($urandom % 4) != 0;
      if (rd_req_valid && rd_req_ready) begin
        logic [AW-1:0] ea;
        ea = q_base + AW'(32'(fetch_pos[ML-1:0]) * 16);
        chk(rd_req_addr == ea, "R3 fetch address", rd_req_addr, ea);
        cnt_fetch++;
        rsp_idx  = int'((rd_req_addr - q_base) >> 4) & (NE - 1);
        rsp_cnt  = $urandom % 3;
        have_rsp = 1'b1;
      end
    end
  end

  task automatic do_reset(input int l);
    @(negedge clk);
    rst_n = 1'b0; q_en = 1'b0; gerr_ack = 1'b0;
    prod_ptr = '0; prod_wrap = 1'b0;
    q_log2sz = LW'(l);
    lgc = (l > ML) ? ML : l;
    fetch_pos = '0; exp_pos = '0; exp_gerr = 1'b0;
    for (int i = 0; i < NE; i++) bad[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_pos(input string tag);
    logic [ML:0] act;
    act = {cons_wrap, cons_ptr};
    chk(act == exp_pos, tag, act, exp_pos);
  endtask

  // kind: 0 random, 1 force illegal, 2 force abort, 3 no error
  task automatic batch(input int n, input int kind);
    logic [ML:0] p, cp;
    int err_at, s0, g0, f0, exp_sync, fidx;
    bit err_abt;
    err_at = -1; err_abt = 1'b0; exp_sync = 0; fidx = 0;
    if (kind == 1 || kind == 2 || (kind == 0 && ($urandom % 3) == 0)) begin
      err_at  = $urandom % n;
      err_abt = (kind == 2) || (kind == 0 && $urandom % 2 == 1);
    end
    p = exp_pos;
    for (int i = 0; i < n; i++) begin
      int idx, r;
      idx = int'(p[ML-1:0]);
      r = $urandom % 4;
      bad[idx] = 1'b0;
      mem[idx] = {$urandom, $urandom, $urandom, $urandom};
      if (r == 0)      mem[idx][13:0] = {2'b01, 4'h0, 8'h46};
      else if (r == 1) mem[idx][13:0] = {($urandom % 2 == 0) ? 2'b00 : 2'b10, 4'h0, 8'h46};
      else             mem[idx][7:0]  = nop_op($urandom);
      if (i == err_at) begin
        fidx = idx;
        if (err_abt) bad[idx] = 1'b1;
        else mem[idx][7:0] = ill_op($urandom);
      end
      p = adv(p, lgc);
    end
    cp = exp_pos;
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = int'(cp[ML-1:0]);
      if (i == err_at) break;
      if (mem[idx][7:0] == 8'h46 && mem[idx][13:12] == 2'b01) exp_sync++;
      cp = adv(cp, lgc);
    end
    s0 = cnt_sync; g0 = cnt_gerr;
    prod_ptr = p[ML-1:0]; prod_wrap = p[ML];
    repeat ((n + 2) * 10) @(negedge clk);
    exp_pos = cp;
    check_pos(err_at < 0 ? "R2 R10 drained to producer" : "R6 R7 stopped at faulty command");
    chk(cnt_sync - s0 == exp_sync, "R4 R5 sync pulses", cnt_sync - s0, exp_sync);
    chk(cnt_gerr - g0 == (err_at < 0 ? 0 : 1), "R8 gerr pulses", cnt_gerr - g0, err_at < 0 ? 0 : 1);
    if (err_at >= 0) begin
      exp_gerr = ~exp_gerr;
      chk(gerr_flag == exp_gerr, "R8 gerr flag toggle", gerr_flag, exp_gerr);
      chk(cmd_err == (err_abt ? 2'd2 : 2'd1), err_abt ? "R7 abort code" : "R6 illegal code",
          cmd_err, err_abt ? 2 : 1);
      bad[fidx] = 1'b0;
      mem[fidx][7:0] = nop_op($urandom);
      f0 = cnt_fetch;
      repeat (25) @(negedge clk);
      chk(cnt_fetch == f0, "R9 frozen while pending", cnt_fetch, f0);
      check_pos("R9 index held while pending");
      gerr_ack = gerr_flag;
      repeat ((n + 2) * 10) @(negedge clk);
      exp_pos = p;
      check_pos("R9 resumed after acknowledge");
      chk(cnt_fetch > f0, "R9 fetch restarts at faulty slot", cnt_fetch, f0 + 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < NE; i++) mem[i] = {120'h0, 8'h10};
    do_reset(2);
    chk(cons_ptr == 0 && cons_wrap == 0, "R12 reset index", {cons_wrap, cons_ptr}, 0);
    chk(cmd_err == 0 && gerr_flag == 0, "R12 reset error state", {gerr_flag, cmd_err}, 0);
    chk(!rd_req_valid && !irq_sync && !irq_gerr, "R12 reset idle",
        {rd_req_valid, irq_sync, irq_gerr}, 0);

    prod_ptr = 4'd3;
    repeat (40) @(negedge clk);
    chk(cnt_fetch == 0, "R1 no fetch while disabled", cnt_fetch, 0);
    check_pos("R1 index held while disabled");
    q_en = 1'b1;
    repeat (50) @(negedge clk);
    exp_pos = 5'd3;
    check_pos("R2 drained after enable");

    for (int b = 0; b < 10; b++) batch(1 + ($urandom % 4), 0);
    batch(4, 3);
    batch(3, 1);
    batch(4, 2);

    do_reset(0);
    q_en = 1'b1;
    for (int b = 0; b < 6; b++) batch(1, b == 3 ? 1 : 3);

    do_reset(6);
    q_en = 1'b1;
    batch(16, 3);
    for (int b = 0; b < 14; b++) batch(1 + ($urandom % 16), 0);
    batch(16, 2);
    batch(9, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule